// File: doc/BRIEF.md
# Transaction Address Router for a Memory Controller Hub

This block sits at the center of a single-processor memory controller hub. It takes one request at a time from one of three requesters: the host processor, the graphics port or the downstream hub link. For each request it picks a destination, which is local DRAM, the graphics port or the hub link. It also decides whether the access must raise a snoop on the host bus. Any memory address that falls inside the graphics aperture is remapped page by page through a small translation table, whatever requester issued it.

Decoding is positive where a range claims the address and subtractive otherwise. I/O cycles are never claimed and always drop through to the hub link. Host memory cycles are checked against the graphics window and the DRAM range, and anything unclaimed goes to the hub. The aperture base, the aperture size mask, the graphics window and the DRAM limit come in as configuration inputs that are held steady while traffic flows. The table is loaded through a simple write port.

The decision is registered. A request that is accepted on a clock edge shows up on the route side one cycle later. Both sides use a valid/ready handshake.

Top module: `txnRouter`

## Requirements
- R1: Reset leaves `routeValid` low and `reqReady` high.
- R2: A request with `reqIsIo`=1 from any source routes to the hub link (target code 3) with no snoop and an untranslated address.
- R3: A host memory request (source code 0) that misses the aperture routes to the graphics port (target code 2) if `(addr ^ gfxWinBase) & gfxWinMask` is zero. Otherwise it routes to DRAM (target code 1) if `addr < dramLimit`. Otherwise it routes to the hub link (code 3).
- R4: A memory request from any source whose address satisfies `(addr ^ aperBase) & aperMask == 0` hits the aperture. Its table index is `addr[15:12]`. If that entry is valid, the request routes to DRAM with `routeAddr = {pfn, addr[11:0]}`.
- R5: An aperture hit on an invalid table entry sets `routeErr`, gives target code 0 (none) and no snoop, and passes the address through untranslated. Rewriting that entry as valid makes the same address translate.
- R6: A request that routes to DRAM sets `routeSnoop` when it comes from the hub link (source code 2 or the reserved code 3), or from the graphics port (source code 1) with `reqNative`=0. A DRAM route from the host, or from the graphics port with `reqNative`=1, does not snoop.
- R7: `routeSnoopAddr` equals `routeAddr` with bits [5:0] cleared when `routeSnoop` is set. It is zero otherwise.
- R8: A memory request from the graphics port or the hub link that misses the aperture routes to DRAM if `addr < dramLimit`, and to the hub link otherwise. The graphics window is ignored for these sources.
- R9: A request accepted on a clock edge (`reqValid && reqReady`) gives `routeValid` high after that edge. With `routeReady` high and no new request, `routeValid` falls after the next edge.
- R10: While `routeValid` is high and `routeReady` is low, `reqReady` is low and every route output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Router can take a request this cycle |
| reqSrc | input | 2 | Requester: 0 host, 1 graphics port, 2 hub link, 3 reserved (treated as hub) |
| reqIsIo | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| reqNative | input | 1 | 1 = native graphics semantics, 0 = PCI semantics |
| reqAddr | input | 32 | Request address |
| dramLimit | input | 32 | DRAM occupies addresses below this value |
| gfxWinBase | input | 32 | Graphics port window base |
| gfxWinMask | input | 32 | Upper-bit mask that sets the window size |
| aperBase | input | 32 | Graphics aperture base |
| aperMask | input | 32 | Upper-bit mask that sets the aperture size |
| tblWrEn | input | 1 | Translation table write strobe |
| tblWrIdx | input | 4 | Table entry to write |
| tblWrPfn | input | 20 | Page frame number to store |
| tblWrValid | input | 1 | Valid bit to store |
| routeValid | output | 1 | Routing decision present |
| routeReady | input | 1 | Consumer takes the decision |
| routeTarget | output | 2 | 0 none, 1 DRAM, 2 graphics port, 3 hub link |
| routeSnoop | output | 1 | Host-bus snoop required |
| routeErr | output | 1 | Aperture hit on an invalid table entry |
| routeAddr | output | 32 | Routed (possibly translated) address |
| routeSnoopAddr | output | 32 | Cache-line address to snoop, or zero |

## Verification
The hardest situation to reach from the ports is an aperture hit from an upstream requester that lands on an invalid entry while the output is stalled. Here the error path, the snoop rule and the hold behaviour all meet. The bench leaves one table entry invalid on purpose and sweeps every source, cycle type and semantics setting across addresses just inside and just outside each range edge. It then checks the invalid-entry address again after rewriting that entry. Separate directed scenarios hold `routeReady` low while a second request waits, then release it. This shows that the first decision survives and that the waiting request is taken on the release edge.

// File: rtl/txnroute_pkg.sv
package txnroute_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DRAM = 2'd1,
    TGT_GFX  = 2'd2,
    TGT_HUB  = 2'd3
  } target_e;

  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_GFX  = 2'd1,
    SRC_HUB  = 2'd2,
    SRC_RSVD = 2'd3
  } source_e;

  // range comparisons reported by the datapath
  typedef struct packed {
    logic aperHit;
    logic entryOk;
    logic winHit;
    logic dramHit;
  } decodeHits_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic xlat;
    logic snoop;
  } dpStrobes_t;

endpackage

// File: rtl/routeCtrl.sv
module routeCtrl
  import txnroute_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqSrc,
  input  logic        reqIsIo,
  input  logic        reqNative,
  input  decodeHits_t hits,
  output dpStrobes_t  strobes,
  input  logic        routeReady,
  output logic        routeValid,
  output logic [1:0]  routeTarget,
  output logic        routeSnoop,
  output logic        routeErr
);

  source_e srcKind;
  target_e tgtNext;
  logic    errNext;
  logic    xlatNext;
  logic    snoopNext;
  logic    accept;
  logic    validQ;
  target_e tgtQ;
  logic    snoopQ;
  logic    errQ;

  assign srcKind  = source_e'(reqSrc);
  assign reqReady = !validQ || routeReady;
  assign accept   = reqValid && reqReady;

  // aperture first, then host-only window, then DRAM, hub by default
  always_comb begin
    tgtNext  = TGT_HUB;
    errNext  = 1'b0;
    xlatNext = 1'b0;
    if (!reqIsIo) begin
      if (hits.aperHit) begin
        if (hits.entryOk) begin
          tgtNext  = TGT_DRAM;
          xlatNext = 1'b1;
        end else begin
          tgtNext = TGT_NONE;
          errNext = 1'b1;
        end
      end else if (srcKind == SRC_HOST && hits.winHit) begin
        tgtNext = TGT_GFX;
      end else if (hits.dramHit) begin
        tgtNext = TGT_DRAM;
      end
    end
  end

  always_comb begin
    snoopNext = 1'b0;
    if (tgtNext == TGT_DRAM) begin
      case (srcKind)
        SRC_HOST: snoopNext = 1'b0;
        SRC_GFX:  snoopNext = !reqNative;
        default:  snoopNext = 1'b1;
      endcase
    end
  end

  assign strobes.load  = accept;
  assign strobes.xlat  = xlatNext;
  assign strobes.snoop = snoopNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      tgtQ   <= TGT_NONE;
      snoopQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      if (accept) begin
        validQ <= 1'b1;
        tgtQ   <= tgtNext;
        snoopQ <= snoopNext;
        errQ   <= errNext;
      end else if (routeReady) begin
        validQ <= 1'b0;
      end
    end
  end

  assign routeValid  = validQ;
  assign routeTarget = tgtQ;
  assign routeSnoop  = snoopQ;
  assign routeErr    = errQ;

endmodule

// File: rtl/routeDatapath.sv
module routeDatapath
  import txnroute_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_W      = 12,
  parameter int LINE_W      = 6,
  parameter int TBL_ENTRIES = 16,
  localparam int IDX_W      = $clog2(TBL_ENTRIES),
  localparam int PFN_W      = ADDR_W - PAGE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] dramLimit,
  input  logic [ADDR_W-1:0] gfxWinBase,
  input  logic [ADDR_W-1:0] gfxWinMask,
  input  logic [ADDR_W-1:0] aperBase,
  input  logic [ADDR_W-1:0] aperMask,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic [PFN_W-1:0]  tblWrPfn,
  input  logic              tblWrValid,
  input  dpStrobes_t        strobes,
  output decodeHits_t       hits,
  output logic [ADDR_W-1:0] routeAddr,
  output logic [ADDR_W-1:0] routeSnoopAddr
);

  logic [PFN_W-1:0]       pfnArr [TBL_ENTRIES];
  logic [TBL_ENTRIES-1:0] vldVec;
  logic [IDX_W-1:0]       pageIdx;
  logic [ADDR_W-1:0]      xlatAddr;
  logic [ADDR_W-1:0]      nextAddr;
  logic [ADDR_W-1:0]      addrQ;
  logic [ADDR_W-1:0]      snoopAddrQ;

  // one register slice per table entry
  for (genvar e = 0; e < TBL_ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pfnArr[e] <= '0;
      end else if (tblWrEn && tblWrIdx == IDX_W'(e)) begin
        pfnArr[e] <= tblWrPfn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldVec <= '0;
    end else if (tblWrEn) begin
      vldVec[tblWrIdx] <= tblWrValid;
    end
  end

  assign pageIdx = reqAddr[PAGE_W +: IDX_W];

  assign hits.aperHit = ((reqAddr ^ aperBase) & aperMask) == '0;
  assign hits.winHit  = ((reqAddr ^ gfxWinBase) & gfxWinMask) == '0;
  assign hits.dramHit = reqAddr < dramLimit;
  assign hits.entryOk = vldVec[pageIdx];

  assign xlatAddr = {pfnArr[pageIdx], reqAddr[PAGE_W-1:0]};
  assign nextAddr = strobes.xlat ? xlatAddr : reqAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ      <= '0;
      snoopAddrQ <= '0;
    end else if (strobes.load) begin
      addrQ      <= nextAddr;
      snoopAddrQ <= strobes.snoop ? {nextAddr[ADDR_W-1:LINE_W], {LINE_W{1'b0}}} : '0;
    end
  end

  assign routeAddr      = addrQ;
  assign routeSnoopAddr = snoopAddrQ;

endmodule

// File: rtl/txnRouter.sv
module txnRouter
  import txnroute_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_W      = 12,
  parameter int LINE_W      = 6,
  parameter int TBL_ENTRIES = 16,
  localparam int IDX_W      = $clog2(TBL_ENTRIES),
  localparam int PFN_W      = ADDR_W - PAGE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqSrc,
  input  logic              reqIsIo,
  input  logic              reqNative,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] dramLimit,
  input  logic [ADDR_W-1:0] gfxWinBase,
  input  logic [ADDR_W-1:0] gfxWinMask,
  input  logic [ADDR_W-1:0] aperBase,
  input  logic [ADDR_W-1:0] aperMask,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic [PFN_W-1:0]  tblWrPfn,
  input  logic              tblWrValid,
  output logic              routeValid,
  input  logic              routeReady,
  output logic [1:0]        routeTarget,
  output logic              routeSnoop,
  output logic              routeErr,
  output logic [ADDR_W-1:0] routeAddr,
  output logic [ADDR_W-1:0] routeSnoopAddr
);

  decodeHits_t hits;
  dpStrobes_t  strobes;

  routeCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .reqSrc     (reqSrc),
    .reqIsIo    (reqIsIo),
    .reqNative  (reqNative),
    .hits       (hits),
    .strobes    (strobes),
    .routeReady (routeReady),
    .routeValid (routeValid),
    .routeTarget(routeTarget),
    .routeSnoop (routeSnoop),
    .routeErr   (routeErr)
  );

  routeDatapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .LINE_W     (LINE_W),
    .TBL_ENTRIES(TBL_ENTRIES)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .reqAddr       (reqAddr),
    .dramLimit     (dramLimit),
    .gfxWinBase    (gfxWinBase),
    .gfxWinMask    (gfxWinMask),
    .aperBase      (aperBase),
    .aperMask      (aperMask),
    .tblWrEn       (tblWrEn),
    .tblWrIdx      (tblWrIdx),
    .tblWrPfn      (tblWrPfn),
    .tblWrValid    (tblWrValid),
    .strobes       (strobes),
    .hits          (hits),
    .routeAddr     (routeAddr),
    .routeSnoopAddr(routeSnoopAddr)
  );

endmodule

// File: rtl/routeChk.sv
module routeChk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 6
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqIsIo,
  input logic              routeValid,
  input logic              routeReady,
  input logic [1:0]        routeTarget,
  input logic              routeSnoop,
  input logic              routeErr,
  input logic [ADDR_W-1:0] routeAddr,
  input logic [ADDR_W-1:0] routeSnoopAddr
);

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> routeValid);

  // R2
  io_to_hub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqIsIo) |=> (routeTarget == 2'd3 && !routeSnoop));

  // R10
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && !routeReady) |-> !reqReady);

  // R10
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && !routeReady) |=> (routeValid && $stable(routeTarget) && $stable(routeAddr)
                                     && $stable(routeSnoop) && $stable(routeErr)));

  // R5
  err_no_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routeErr) |-> (routeTarget == 2'd0 && !routeSnoop));

  // R6
  snoop_only_dram_chk: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routeSnoop) |-> routeTarget == 2'd1);

  // R7
  snoop_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routeSnoop) |-> routeSnoopAddr == {routeAddr[ADDR_W-1:LINE_W], {LINE_W{1'b0}}});

endmodule

bind txnRouter routeChk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) uRouteChk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .reqIsIo       (reqIsIo),
  .routeValid    (routeValid),
  .routeReady    (routeReady),
  .routeTarget   (routeTarget),
  .routeSnoop    (routeSnoop),
  .routeErr      (routeErr),
  .routeAddr     (routeAddr),
  .routeSnoopAddr(routeSnoopAddr)
);

// File: tb/tb_txnRouter.sv
`timescale 1ns/1ps
module tb_txnRouter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqSrc = 2'd0;
  logic        reqIsIo = 1'b0;
  logic        reqNative = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] dramLimit  = 32'h2000_0000;
  logic [31:0] gfxWinBase = 32'hD000_0000;
  logic [31:0] gfxWinMask = 32'hF000_0000;
  logic [31:0] aperBase   = 32'hE000_0000;
  logic [31:0] aperMask   = 32'hFFFF_0000;
  logic        tblWrEn = 1'b0;
  logic [3:0]  tblWrIdx = '0;
  logic [19:0] tblWrPfn = '0;
  logic        tblWrValid = 1'b0;
  logic        routeValid;
  logic        routeReady = 1'b1;
  logic [1:0]  routeTarget;
  logic        routeSnoop;
  logic        routeErr;
  logic [31:0] routeAddr;
  logic [31:0] routeSnoopAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [19:0] refPfn [16];
  logic        refVld [16];

  always #10 clk = ~clk;

  txnRouter dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSrc(reqSrc), .reqIsIo(reqIsIo), .reqNative(reqNative), .reqAddr(reqAddr),
    .dramLimit(dramLimit), .gfxWinBase(gfxWinBase), .gfxWinMask(gfxWinMask),
    .aperBase(aperBase), .aperMask(aperMask), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrPfn(tblWrPfn), .tblWrValid(tblWrValid), .routeValid(routeValid),
    .routeReady(routeReady), .routeTarget(routeTarget), .routeSnoop(routeSnoop),
    .routeErr(routeErr), .routeAddr(routeAddr), .routeSnoopAddr(routeSnoopAddr)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: {err, target, snoop, addr}
  function automatic logic [35:0] model(logic [1:0] s, logic io, logic nat, logic [31:0] a);
    logic [1:0]  t = 2'd3;
    logic        e = 1'b0;
    logic        sn = 1'b0;
    logic [31:0] o = a;
    if (!io) begin
      if ((a & 32'hFFFF_0000) == 32'hE000_0000) begin
        if (refVld[a[15:12]]) begin t = 2'd1; o = {refPfn[a[15:12]], a[11:0]}; end
        else begin t = 2'd0; e = 1'b1; end
      end else if (s == 2'd0 && a[31:28] == 4'hD) t = 2'd2;
      else if (a < 32'h2000_0000) t = 2'd1;
    end
    if (t == 2'd1) sn = (s == 2'd1) ? !nat : (s != 2'd0);
    return {e, t, sn, o};
  endfunction

  function automatic string tagFor(logic [1:0] s, logic io, logic [35:0] m);
    if (io) return "R2";
    if (m[35]) return "R5";
    if (m[34:33] == 2'd1 && m[31:0] != 32'h0 && m[32]) return "R6";
    if (s == 2'd0) return "R3";
    return "R8";
  endfunction

  task automatic writeEntry(int idx, logic [19:0] pfn, logic v);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = 4'(idx); tblWrPfn = pfn; tblWrValid = v;
    @(negedge clk);
    tblWrEn = 1'b0;
    refPfn[idx] = pfn; refVld[idx] = v;
  endtask

  task automatic sendReq(logic [1:0] s, logic io, logic nat, logic [31:0] a);
    @(negedge clk);
    reqSrc = s; reqIsIo = io; reqNative = nat; reqAddr = a; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkOut(string tag, logic [35:0] m);
    logic [31:0] sa;
    sa = m[32] ? {m[31:6], 6'b0} : 32'h0;
    check({tag, " route"}, {routeValid, routeErr, routeTarget, routeSnoop, routeAddr},
                           {1'b1, m[35], m[34:33], m[32], m[31:0]});
    check("R7 snoopAddr", routeSnoopAddr, sa);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset", {routeValid, reqReady}, {1'b0, 1'b1});
  endtask

  task automatic testSweep();
    logic [31:0] addrs [12];
    addrs = '{32'h0000_0000, 32'h1FFF_FFFF, 32'h2000_0000, 32'hCFFF_FFFF,
              32'hD000_0000, 32'hDFFF_FFFF, 32'hDFFF_FFC7, 32'hE000_0000,
              32'hE000_FFFF, 32'hE000_5ABC, 32'hE001_0000, 32'hFFFF_FFFF};
    for (int s = 0; s < 3; s++)
      for (int io = 0; io < 2; io++)
        for (int nat = 0; nat < 2; nat++)
          for (int k = 0; k < 12; k++) begin
            logic [35:0] m;
            m = model(2'(s), io[0], nat[0], addrs[k]);
            sendReq(2'(s), io[0], nat[0], addrs[k]);
            checkOut(tagFor(2'(s), io[0], m), m);
          end
  endtask

  task automatic testSnoopRules();
    // R6: hub-side DRAM access snoops; host and native graphics do not
    sendReq(2'd2, 1'b0, 1'b1, 32'h0000_1047);
    check("R6 hub snoop", {routeTarget, routeSnoop, routeSnoopAddr}, {2'd1, 1'b1, 32'h0000_1040});
    sendReq(2'd3, 1'b0, 1'b0, 32'h0000_2FFF);
    check("R6 rsvd snoop", {routeTarget, routeSnoop}, {2'd1, 1'b1});
    sendReq(2'd1, 1'b0, 1'b1, 32'h0000_2FFF);
    check("R6 native no snoop", {routeTarget, routeSnoop, routeSnoopAddr}, {2'd1, 1'b0, 32'h0});
    sendReq(2'd0, 1'b0, 1'b0, 32'h0000_2FFF);
    check("R6 host no snoop", {routeTarget, routeSnoop}, {2'd1, 1'b0});
  endtask

  task automatic testAperture();
    // R4: translated address from page 3, line-cleared snoop address for graphics PCI
    sendReq(2'd1, 1'b0, 1'b0, 32'hE000_3FC5);
    check("R4 xlat", {routeTarget, routeAddr}, {2'd1, refPfn[3], 12'hFC5});
    check("R7 xlat line", routeSnoopAddr, {refPfn[3], 12'hFC0});
    // R5: invalid entry, then fix it and retry
    sendReq(2'd0, 1'b0, 1'b0, 32'hE000_5123);
    check("R5 invalid", {routeErr, routeTarget, routeAddr}, {1'b1, 2'd0, 32'hE000_5123});
    writeEntry(5, 20'hABCDE, 1'b1);
    sendReq(2'd0, 1'b0, 1'b0, 32'hE000_5123);
    check("R5 fixed", {routeErr, routeTarget, routeAddr}, {1'b0, 2'd1, 32'hABCD_E123});
    writeEntry(5, 20'h0, 1'b0);
  endtask

  task automatic testLatency();
    @(negedge clk);
    check("R9 idle", routeValid, 1'b0);
    reqSrc = 2'd0; reqIsIo = 1'b1; reqAddr = 32'h0000_03F8; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 one cycle", {routeValid, routeTarget}, {1'b1, 2'd3});
    @(negedge clk);
    check("R9 drain", routeValid, 1'b0);
  endtask

  task automatic testBackpressure();
    @(negedge clk);
    routeReady = 1'b0;
    reqSrc = 2'd0; reqIsIo = 1'b0; reqNative = 1'b0; reqAddr = 32'hD000_0040; reqValid = 1'b1;
    @(negedge clk);
    reqAddr = 32'h0000_0080; reqSrc = 2'd2;
    check("R10 first held", {routeValid, reqReady, routeTarget, routeAddr},
                            {1'b1, 1'b0, 2'd2, 32'hD000_0040});
    @(negedge clk);
    check("R10 still held", {routeValid, reqReady, routeTarget, routeAddr},
                            {1'b1, 1'b0, 2'd2, 32'hD000_0040});
    routeReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 release", {routeValid, routeTarget, routeSnoop, routeAddr},
                         {1'b1, 2'd1, 1'b1, 32'h0000_0080});
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin refPfn[i] = '0; refVld[i] = 1'b0; end
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++)
      writeEntry(i, 20'h10000 + 20'(i * 3), (i != 5));
    testLatency();
    testSnoopRules();
    testAperture();
    testBackpressure();
    testSweep();
    finishRun();
  end

endmodule